// File: doc/BRIEF.md
# Endpoint-0 Control Handshake Register

This block is the status and control register between a processor and the engine that runs the USB default control endpoint. It holds six flags: OUT packet ready, IN packet ready, sent stall, data end, setup end and send stall. Each flag has its own rule about who may set it and who may clear it. The processor reaches the block through a simple register bus with a write strobe, an address, write data and combinational read data. The USB side delivers single-cycle event pulses: a valid token was stored, an IN packet was delivered, a protocol error occurred, a transfer ended early, and the status stage completed.

The block raises a one-cycle interrupt pulse for each event the processor must handle. While an early termination (setup end) is pending, it holds a FIFO flush request and blocks processor FIFO requests. A second register holds the maximum packet size as a one-hot code and decodes it to a byte count for the engine.

Top module: `ep0_hs_reg`

## Requirements
- R1: After reset every flag is 0, the packet-size code is 0x00, the byte count is 0, irq is 0, and both registers read as 0.
- R2: At CTRL_ADDR (0) the read word carries out-ready in bit 0, in-ready in bit 1, sent-stall in bit 2, data-end in bit 3, setup-end in bit 4 and send-stall in bit 5. Bits 6 and 7 always read 0, and bits 31:8 read 0. At MPS_ADDR (1) the code is in bits 7:0 with zeros above. Every other address reads 0 and ignores writes.
- R3: OUT-ready is set in the cycle after usb_tok_valid. Only a control write with bit 6 = 1 clears it. Writing bit 0 has no effect. When the token and the clear arrive in the same cycle, the flag stays set.
- R4: A control write with bit 1 = 1 sets IN-ready, and writing 0 there has no effect. usb_in_done clears it. When the software set and usb_in_done arrive in the same cycle, the flag is 1.
- R5: usb_proto_err sets sent-stall. A control write with bit 2 = 0 clears it, and writing 1 there has no effect. When the error and the clear arrive in the same cycle, the flag stays set.
- R6: A control write with bit 3 = 1 sets data-end, and writing 0 there has no effect. usb_xfer_done clears it. When the software set and usb_xfer_done arrive in the same cycle, the flag is 1.
- R7: usb_early_end sets setup-end only while data-end is 0. A control write with bit 7 = 1 clears it. When the set and the clear arrive in the same cycle, the flag stays set.
- R8: While setup-end is 1, fifo_flush is 1 and fifo_grant is 0. Otherwise fifo_flush is 0 and fifo_grant equals cpu_fifo_req.
- R9: Every control write loads bit 5 into send-stall, and stall_req shows that flag.
- R10: irq pulses for one cycle, in the cycle after any of these events:
  - usb_tok_valid while out-ready is 0;
  - usb_in_done while in-ready is 1;
  - usb_proto_err while sent-stall is 0;
  - a qualifying usb_early_end while setup-end is 0.
- R11: A write at MPS_ADDR stores the value only if it is 0x01, 0x02, 0x04 or 0x08; any other value is ignored. mps_bytes is 8, 16, 32 or 64 for those codes, and 0 when the code is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | FIELD_W | Write data (the implemented low byte) |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| usb_tok_valid | input | 1 | Valid token stored in FIFO |
| usb_in_done | input | 1 | IN packet accepted by host |
| usb_proto_err | input | 1 | Control transaction ended on protocol error |
| usb_early_end | input | 1 | Control transfer terminated early |
| usb_xfer_done | input | 1 | Status stage finished, ends data phase |
| cpu_fifo_req | input | 1 | Processor FIFO access request |
| fifo_grant | output | 1 | Processor FIFO access allowed |
| fifo_flush | output | 1 | FIFO flush request |
| out_pkt_rdy | output | 1 | OUT-ready flag |
| in_pkt_rdy | output | 1 | IN-ready flag |
| data_end | output | 1 | Data-end flag |
| stall_req | output | 1 | Send-stall flag to the engine |
| mps_code | output | FIELD_W | Stored packet-size code |
| mps_bytes | output | MPS_BYTES_W | Decoded packet size in bytes |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its defaults: a 32-bit read word, 8-bit fields, a 4-bit address and four size codes from 8 to 64 bytes. The 4-bit address leaves fourteen unmapped addresses, so random traffic hits them and the check that they ignore writes is exercised. The four size codes make every legal code and a large set of illegal byte values reachable. Directed sequences force each same-cycle collision between a hardware event and a software write. Random traffic then mixes these collisions with the interrupt qualification conditions.

// File: rtl/ep0_hs_pkg.sv
package ep0_hs_pkg;

    // Control word bit positions (software-visible layout)
    localparam int unsigned B_OUT_RDY    = 0;
    localparam int unsigned B_IN_RDY     = 1;
    localparam int unsigned B_SENT_STALL = 2;
    localparam int unsigned B_DATA_END   = 3;
    localparam int unsigned B_SETUP_END  = 4;
    localparam int unsigned B_SEND_STALL = 5;
    localparam int unsigned B_CLR_OUT    = 6;
    localparam int unsigned B_CLR_SETUP  = 7;

    typedef struct packed {
        logic setup_end;
        logic send_stall;
        logic data_end;
        logic sent_stall;
        logic in_rdy;
        logic out_rdy;
    } ep0_flags_t;

    typedef struct packed {
        logic tok_valid;
        logic in_done;
        logic proto_err;
        logic early_end;
        logic xfer_done;
    } usb_evt_t;

endpackage

// File: rtl/ep0_flag_ctrl.sv
module ep0_flag_ctrl
    import ep0_hs_pkg::*;
#(
    parameter int unsigned FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic [FIELD_W-1:0] ctrl_wdata,
    input  usb_evt_t           evt,
    output ep0_flags_t         flags_o,
    output logic               irq_o
);

    typedef struct packed {
        ep0_flags_t flags;
        logic       irq;
    } flag_state_t;

    flag_state_t s_d, s_q;
    logic        early_hit;

    always_comb begin
        s_d       = s_q;
        s_d.irq   = 1'b0;
        early_hit = evt.early_end && !s_q.flags.data_end;

        // OUT ready: hardware set, strobe clear, set wins
        if (ctrl_wr && ctrl_wdata[B_CLR_OUT]) s_d.flags.out_rdy = 1'b0;
        if (evt.tok_valid)                    s_d.flags.out_rdy = 1'b1;

        // IN ready: software set, hardware clear, software set wins
        if (evt.in_done)                      s_d.flags.in_rdy = 1'b0;
        if (ctrl_wr && ctrl_wdata[B_IN_RDY])  s_d.flags.in_rdy = 1'b1;

        // Sent stall: hardware set, software write-zero clear, set wins
        if (ctrl_wr && !ctrl_wdata[B_SENT_STALL]) s_d.flags.sent_stall = 1'b0;
        if (evt.proto_err)                        s_d.flags.sent_stall = 1'b1;

        // Data end: software set, hardware clear, software set wins
        if (evt.xfer_done)                     s_d.flags.data_end = 1'b0;
        if (ctrl_wr && ctrl_wdata[B_DATA_END]) s_d.flags.data_end = 1'b1;

        // Setup end: qualified hardware set, strobe clear, set wins
        if (ctrl_wr && ctrl_wdata[B_CLR_SETUP]) s_d.flags.setup_end = 1'b0;
        if (early_hit)                          s_d.flags.setup_end = 1'b1;

        // Send stall: plain software-written bit
        if (ctrl_wr) s_d.flags.send_stall = ctrl_wdata[B_SEND_STALL];

        // Interrupt events, qualified on the flag's previous value
        s_d.irq = (evt.tok_valid && !s_q.flags.out_rdy)
               || (evt.in_done   &&  s_q.flags.in_rdy)
               || (evt.proto_err && !s_q.flags.sent_stall)
               || (early_hit     && !s_q.flags.setup_end);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags_o = s_q.flags;
    assign irq_o   = s_q.irq;

endmodule

// File: rtl/ep0_mps_reg.sv
module ep0_mps_reg #(
    parameter int unsigned FIELD_W     = 8,
    parameter int unsigned MPS_CODES   = 4,
    parameter int unsigned MPS_BASE    = 8,
    parameter int unsigned MPS_BYTES_W = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [FIELD_W-1:0]     wdata,
    output logic [FIELD_W-1:0]     code_o,
    output logic [MPS_BYTES_W-1:0] bytes_o
);

    typedef struct packed {
        logic [FIELD_W-1:0] code;
    } mps_state_t;

    mps_state_t s_d, s_q;

    logic [MPS_CODES-1:0]   hit_wr;
    logic [MPS_CODES-1:0]   hit_cur;
    logic [MPS_BYTES_W-1:0] size_of [MPS_CODES];

    for (genvar i = 0; i < MPS_CODES; i++) begin : g_code
        localparam logic [FIELD_W-1:0] CODE = FIELD_W'(1) << i;
        assign hit_wr[i]  = (wdata == CODE);
        assign hit_cur[i] = (s_q.code == CODE);
        assign size_of[i] = MPS_BYTES_W'(MPS_BASE) << i;
    end

    always_comb begin
        s_d = s_q;
        if (wr && (|hit_wr)) s_d.code = wdata;
    end

    always_comb begin
        bytes_o = '0;
        for (int i = 0; i < MPS_CODES; i++) begin
            if (hit_cur[i]) bytes_o = bytes_o | size_of[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o = s_q.code;

endmodule

// File: rtl/ep0_bus_read.sv
module ep0_bus_read
    import ep0_hs_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned FIELD_W   = 8,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CTRL_ADDR = 0,
    parameter int unsigned MPS_ADDR  = 1
) (
    input  logic [ADDR_W-1:0]  addr,
    input  ep0_flags_t         flags,
    input  logic [FIELD_W-1:0] mps_code,
    output logic [DATA_W-1:0]  rdata
);

    logic [FIELD_W-1:0] ctrl_word;

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[B_OUT_RDY]     = flags.out_rdy;
        ctrl_word[B_IN_RDY]      = flags.in_rdy;
        ctrl_word[B_SENT_STALL]  = flags.sent_stall;
        ctrl_word[B_DATA_END]    = flags.data_end;
        ctrl_word[B_SETUP_END]   = flags.setup_end;
        ctrl_word[B_SEND_STALL]  = flags.send_stall;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_ADDR)) begin
            rdata[FIELD_W-1:0] = ctrl_word;
        end else if (addr == ADDR_W'(MPS_ADDR)) begin
            rdata[FIELD_W-1:0] = mps_code;
        end
    end

endmodule

// File: rtl/ep0_hs_reg.sv
module ep0_hs_reg
    import ep0_hs_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned FIELD_W     = 8,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned CTRL_ADDR   = 0,
    parameter int unsigned MPS_ADDR    = 1,
    parameter int unsigned MPS_CODES   = 4,
    parameter int unsigned MPS_BASE    = 8,
    parameter int unsigned MPS_BYTES_W = $clog2(MPS_BASE << (MPS_CODES - 1)) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr_en,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [FIELD_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic                   usb_tok_valid,
    input  logic                   usb_in_done,
    input  logic                   usb_proto_err,
    input  logic                   usb_early_end,
    input  logic                   usb_xfer_done,
    input  logic                   cpu_fifo_req,
    output logic                   fifo_grant,
    output logic                   fifo_flush,
    output logic                   out_pkt_rdy,
    output logic                   in_pkt_rdy,
    output logic                   data_end,
    output logic                   stall_req,
    output logic [FIELD_W-1:0]     mps_code,
    output logic [MPS_BYTES_W-1:0] mps_bytes,
    output logic                   irq
);

    ep0_flags_t flags_w;
    usb_evt_t   evt_w;
    logic       ctrl_wr_w;
    logic       mps_wr_w;
    logic       sent_stall_w;
    logic       setup_end_w;

    assign ctrl_wr_w = bus_wr_en && (bus_addr == ADDR_W'(CTRL_ADDR));
    assign mps_wr_w  = bus_wr_en && (bus_addr == ADDR_W'(MPS_ADDR));

    assign evt_w.tok_valid = usb_tok_valid;
    assign evt_w.in_done   = usb_in_done;
    assign evt_w.proto_err = usb_proto_err;
    assign evt_w.early_end = usb_early_end;
    assign evt_w.xfer_done = usb_xfer_done;

    ep0_flag_ctrl #(
        .FIELD_W (FIELD_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr_w),
        .ctrl_wdata (bus_wdata),
        .evt        (evt_w),
        .flags_o    (flags_w),
        .irq_o      (irq)
    );

    ep0_mps_reg #(
        .FIELD_W     (FIELD_W),
        .MPS_CODES   (MPS_CODES),
        .MPS_BASE    (MPS_BASE),
        .MPS_BYTES_W (MPS_BYTES_W)
    ) u_mps (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (mps_wr_w),
        .wdata   (bus_wdata),
        .code_o  (mps_code),
        .bytes_o (mps_bytes)
    );

    ep0_bus_read #(
        .DATA_W    (DATA_W),
        .FIELD_W   (FIELD_W),
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .MPS_ADDR  (MPS_ADDR)
    ) u_rd (
        .addr     (bus_addr),
        .flags    (flags_w),
        .mps_code (mps_code),
        .rdata    (bus_rdata)
    );

    assign sent_stall_w = flags_w.sent_stall;
    assign setup_end_w  = flags_w.setup_end;
    assign out_pkt_rdy  = flags_w.out_rdy;
    assign in_pkt_rdy   = flags_w.in_rdy;
    assign data_end     = flags_w.data_end;
    assign stall_req    = flags_w.send_stall;

    // Setup-end abort isolates the FIFO from the processor
    assign fifo_flush = setup_end_w;
    assign fifo_grant = cpu_fifo_req && !setup_end_w;

endmodule

// File: rtl/ep0_hs_reg_chk.sv
module ep0_hs_reg_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FIELD_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctrl_wr,
    input logic [FIELD_W-1:0] bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               usb_tok_valid,
    input logic               usb_in_done,
    input logic               usb_proto_err,
    input logic               usb_early_end,
    input logic               out_pkt_rdy,
    input logic               in_pkt_rdy,
    input logic               data_end,
    input logic               sent_stall,
    input logic               setup_end,
    input logic               stall_req,
    input logic               fifo_flush,
    input logic               fifo_grant,
    input logic [FIELD_W-1:0] mps_code,
    input logic               irq
);

    AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        usb_tok_valid |=> out_pkt_rdy); // R3

    AST_OUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pkt_rdy && !(ctrl_wr && bus_wdata[6])) |=> out_pkt_rdy); // R3

    AST_IN_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_in_done && !(ctrl_wr && bus_wdata[1])) |=> !in_pkt_rdy); // R4

    AST_SENT_STALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        usb_proto_err |=> sent_stall); // R5

    AST_SETUP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_early_end && data_end && !setup_end && !usb_in_done) |=> !setup_end); // R7

    AST_SETUP_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        setup_end |-> (fifo_flush && !fifo_grant)); // R8

    AST_SEND_STALL_WR: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (stall_req == $past(bus_wdata[5]))); // R9

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((usb_tok_valid && !out_pkt_rdy) || (usb_in_done && in_pkt_rdy)
                   || (usb_proto_err && !sent_stall)
                   || (usb_early_end && !data_end && !setup_end))); // R10

    AST_MPS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mps_code)); // R11

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:FIELD_W] == '0); // R2

endmodule

bind ep0_hs_reg ep0_hs_reg_chk #(
    .DATA_W  (DATA_W),
    .FIELD_W (FIELD_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_wr       (ctrl_wr_w),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .usb_tok_valid (usb_tok_valid),
    .usb_in_done   (usb_in_done),
    .usb_proto_err (usb_proto_err),
    .usb_early_end (usb_early_end),
    .out_pkt_rdy   (out_pkt_rdy),
    .in_pkt_rdy    (in_pkt_rdy),
    .data_end      (data_end),
    .sent_stall    (sent_stall_w),
    .setup_end     (setup_end_w),
    .stall_req     (stall_req),
    .fifo_flush    (fifo_flush),
    .fifo_grant    (fifo_grant),
    .mps_code      (mps_code),
    .irq           (irq)
);

// File: tb/ep0_hs_reg_tb_top.sv
module ep0_hs_reg_tb_top;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned FIELD_W = 8;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned BYTES_W = 7;
    localparam int unsigned N_RAND  = 4000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_wr_en = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [FIELD_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0]  bus_rdata;
    logic usb_tok_valid = 1'b0, usb_in_done = 1'b0, usb_proto_err = 1'b0;
    logic usb_early_end = 1'b0, usb_xfer_done = 1'b0, cpu_fifo_req = 1'b0;
    logic fifo_grant, fifo_flush, out_pkt_rdy, in_pkt_rdy, data_end, stall_req, irq;
    logic [FIELD_W-1:0] mps_code;
    logic [BYTES_W-1:0] mps_bytes;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state built from the requirements
    logic m_out = 0, m_in = 0, m_ss = 0, m_de = 0, m_su = 0, m_st = 0, m_irq = 0;
    logic [FIELD_W-1:0] m_mps = '0;
    logic n_out, n_in, n_ss, n_de, n_su, n_st, n_irq;
    logic [FIELD_W-1:0] n_mps;

    always #2 clk = ~clk;

    ep0_hs_reg dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .usb_tok_valid(usb_tok_valid),
        .usb_in_done(usb_in_done), .usb_proto_err(usb_proto_err),
        .usb_early_end(usb_early_end), .usb_xfer_done(usb_xfer_done),
        .cpu_fifo_req(cpu_fifo_req), .fifo_grant(fifo_grant), .fifo_flush(fifo_flush),
        .out_pkt_rdy(out_pkt_rdy), .in_pkt_rdy(in_pkt_rdy), .data_end(data_end),
        .stall_req(stall_req), .mps_code(mps_code), .mps_bytes(mps_bytes), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
        logic [31:0] r = '0;
        if (a == 0) r[7:0] = {2'b00, m_st, m_su, m_de, m_ss, m_in, m_out};
        else if (a == 1) r[7:0] = m_mps;
        return r;
    endfunction

    function automatic logic [BYTES_W-1:0] exp_bytes(input logic [FIELD_W-1:0] c);
        case (c)
            8'h01: return 7'd8;
            8'h02: return 7'd16;
            8'h04: return 7'd32;
            8'h08: return 7'd64;
            default: return 7'd0;
        endcase
    endfunction

    task automatic predict();
        logic sw = bus_wr_en && (bus_addr == 0);
        logic hit = usb_early_end && !m_de;
        n_out = m_out; n_in = m_in; n_ss = m_ss; n_de = m_de;
        n_su = m_su; n_st = m_st; n_mps = m_mps;
        if (sw && bus_wdata[6]) n_out = 0;
        if (usb_tok_valid) n_out = 1;
        if (usb_in_done) n_in = 0;
        if (sw && bus_wdata[1]) n_in = 1;
        if (sw && !bus_wdata[2]) n_ss = 0;
        if (usb_proto_err) n_ss = 1;
        if (usb_xfer_done) n_de = 0;
        if (sw && bus_wdata[3]) n_de = 1;
        if (sw && bus_wdata[7]) n_su = 0;
        if (hit) n_su = 1;
        if (sw) n_st = bus_wdata[5];
        if (bus_wr_en && bus_addr == 1 &&
            (bus_wdata == 8'h01 || bus_wdata == 8'h02 ||
             bus_wdata == 8'h04 || bus_wdata == 8'h08)) n_mps = bus_wdata;
        n_irq = (usb_tok_valid && !m_out) || (usb_in_done && m_in) ||
                (usb_proto_err && !m_ss) || (hit && !m_su);
    endtask

    task automatic check_all();
        chk("R2", "read word", bus_rdata, exp_read(bus_addr));
        chk("R3", "out_pkt_rdy", 32'(out_pkt_rdy), 32'(m_out));
        chk("R4", "in_pkt_rdy", 32'(in_pkt_rdy), 32'(m_in));
        chk("R6", "data_end", 32'(data_end), 32'(m_de));
        chk("R9", "stall_req", 32'(stall_req), 32'(m_st));
        chk("R8", "fifo_flush", 32'(fifo_flush), 32'(m_su));
        chk("R8", "fifo_grant", 32'(fifo_grant), 32'(cpu_fifo_req && !m_su));
        chk("R10", "irq", 32'(irq), 32'(m_irq));
        chk("R11", "mps_code", 32'(mps_code), 32'(m_mps));
        chk("R11", "mps_bytes", 32'(mps_bytes), 32'(exp_bytes(m_mps)));
        if (bus_addr == 0) begin
            chk("R5", "sent stall bit", 32'(bus_rdata[2]), 32'(m_ss));
            chk("R7", "setup end bit", 32'(bus_rdata[4]), 32'(m_su));
        end
    endtask

    // Inputs are set by the caller just after a clock edge, then one edge passes
    task automatic step();
        predict();
        @(posedge clk);
        #1;
        m_out = n_out; m_in = n_in; m_ss = n_ss; m_de = n_de; m_su = n_su;
        m_st = n_st; m_mps = n_mps; m_irq = n_irq;
        check_all();
    endtask

    task automatic drive(input logic wr, input logic [ADDR_W-1:0] a,
                         input logic [FIELD_W-1:0] d, input logic [4:0] ev,
                         input logic req);
        bus_wr_en = wr; bus_addr = a; bus_wdata = d;
        {usb_tok_valid, usb_in_done, usb_proto_err, usb_early_end, usb_xfer_done} = ev;
        cpu_fifo_req = req;
        step();
    endtask

    localparam logic [4:0] E_NONE = 5'b00000, E_TOK = 5'b10000, E_IND = 5'b01000,
                           E_ERR = 5'b00100, E_EARLY = 5'b00010, E_XFER = 5'b00001;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "irq in reset", 32'(irq), 0);
        chk("R1", "mps_bytes in reset", 32'(mps_bytes), 0);
        bus_addr = 0; #1;
        chk("R1", "control read in reset", bus_rdata, 0);
        bus_addr = 1; #1;
        chk("R1", "size read in reset", bus_rdata, 0);
        chk("R1", "out_pkt_rdy in reset", 32'(out_pkt_rdy), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        drive(0, 0, 0, E_NONE, 1);

        // R3: token sets, writing bit 0 does nothing, collision keeps it set
        drive(0, 0, 0, E_TOK, 0);
        drive(1, 0, 8'h00, E_NONE, 0);
        drive(1, 0, 8'h40, E_TOK, 0);
        drive(1, 0, 8'h40, E_NONE, 0);
        // R4: set, write zero, hardware clear, collision
        drive(1, 0, 8'h02, E_NONE, 0);
        drive(1, 0, 8'h00, E_NONE, 0);
        drive(0, 0, 0, E_IND, 0);
        drive(1, 0, 8'h02, E_NONE, 0);
        drive(1, 0, 8'h02, E_IND, 0);
        // R5: error, collision with clear, write one, clear
        drive(0, 0, 0, E_ERR, 0);
        drive(1, 0, 8'h00, E_ERR, 0);
        drive(1, 0, 8'h04, E_NONE, 0);
        drive(1, 0, 8'h00, E_NONE, 0);
        // R6/R7: data end blocks setup end, then cleared, then early end hits
        drive(1, 0, 8'h08, E_NONE, 1);
        drive(0, 0, 0, E_EARLY, 1);
        drive(1, 0, 8'h08, E_XFER, 1);
        drive(0, 0, 0, E_XFER, 1);
        drive(0, 0, 0, E_EARLY, 1);
        drive(0, 0, 0, E_NONE, 1);
        drive(1, 0, 8'h80, E_EARLY, 1);
        drive(1, 0, 8'h80, E_NONE, 1);
        // R9: send stall follows writes
        drive(1, 0, 8'h20, E_NONE, 0);
        drive(1, 0, 8'h00, E_NONE, 0);
        // R11: legal and illegal size codes
        drive(1, 1, 8'h04, E_NONE, 0);
        drive(1, 1, 8'h03, E_NONE, 0);
        drive(1, 1, 8'h08, E_NONE, 0);
        drive(1, 1, 8'h00, E_NONE, 0);
        drive(1, 1, 8'h10, E_NONE, 0);
        // R2: unmapped address ignores writes
        drive(1, 5, 8'hFF, E_NONE, 0);
        drive(0, 9, 8'h00, E_NONE, 0);

        for (int i = 0; i < N_RAND; i++) begin
            logic [ADDR_W-1:0] a;
            logic [FIELD_W-1:0] d;
            logic [4:0] ev;
            int sel = $urandom_range(0, 9);
            a = (sel < 7) ? 0 : (sel < 9) ? 1 : ADDR_W'($urandom_range(2, 15));
            d = FIELD_W'($urandom);
            if (a == 1 && $urandom_range(0, 1) == 1) d = FIELD_W'(1) << $urandom_range(0, 3);
            ev[4] = ($urandom_range(0, 5) == 0);
            ev[3] = ($urandom_range(0, 5) == 0);
            ev[2] = ($urandom_range(0, 7) == 0);
            ev[1] = ($urandom_range(0, 7) == 0);
            ev[0] = ($urandom_range(0, 5) == 0);
            drive($urandom_range(0, 2) == 0, a, d, ev, $urandom_range(0, 1) == 1);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule